// File: doc/BRIEF.md
# Wakeup-Select Issue Queue

This block sits between the rename stage and a group of ALUs in an out-of-order core. Rename hands it one instruction per cycle, already expressed in physical tags: one destination tag, two source tags, and a flag per source saying whether that operand already exists. The entry parks until both operands are available. Execution units announce finished results by broadcasting destination tags. Every waiting entry compares those tags against its own sources and marks each match as available.

Each cycle the queue looks at every entry whose operands are all available. It sends up to ISSUE_W of them to the ALUs, oldest allocation first, whatever their program order relative to entries still waiting. Output slot 0 carries the oldest chosen entry. A flush input removes every entry whose ROB index is younger than a given index, for recovery from a mispredicted branch.

Each entry is a small state machine with three states. ENT_FREE holds no instruction. ENT_WAIT holds an instruction with at least one operand missing. ENT_RDY holds an instruction that can be picked. The transitions are:
- alloc-ready: ENT_FREE to ENT_RDY.
- alloc-wait: ENT_FREE to ENT_WAIT.
- wakeup: ENT_WAIT to ENT_RDY, when the last missing operand's tag is broadcast.
- issue: ENT_RDY to ENT_FREE.
- flush-kill: ENT_WAIT or ENT_RDY to ENT_FREE.
- hold: an occupied entry stays where it is.

Top module: `wakeup_issue_queue`

## Requirements
- R1: After reset the queue is empty. No `iss_valid` bit is set and `alloc_ready` is 1.
- R2: An instruction is taken when `alloc_valid` and `alloc_ready` are both 1 at a clock edge. `alloc_ready` is 0 while all DEPTH entries are occupied, and an offer made then is dropped.
- R3: A source whose ready flag is 1 at allocation counts as available. An entry with both sources available at allocation is offered for issue in the cycle after allocation.
- R4: A valid broadcast whose tag equals a waiting source marks that source available. An entry whose last missing source is woken this way is offered for issue in the cycle after the broadcast.
- R5: A broadcast in the same cycle an instruction is allocated is applied to the incoming sources, so that wakeup is not lost.
- R6: At most ISSUE_W entries issue per cycle. The issuable entries are ranked by allocation order, oldest first, and slot k carries the k-th ranked entry. Valid slots are packed from slot 0, and a waiting older entry never blocks a younger issuable one.
- R7: An issued entry leaves the queue at the clock edge ending its issue cycle. It never issues again.
- R8: While `flush_valid` is 1, `alloc_ready` is 0. Every entry whose ROB index r satisfies d = (r - `flush_rob`) mod 2^ROB_W with d != 0 and d < 2^(ROB_W-1) is removed at that edge. Such an entry is not offered for issue in the flush cycle. Other entries are kept.
- R9: Broadcasts never alter the stored tag fields of an entry. A broadcast matching a source that is already available has no effect.
- R10: The issue fields of slot k are `iss_op`, `iss_dst`, `iss_src1`, `iss_src2` and `iss_rob`. They equal the values given at allocation for the entry in that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Rename offers an instruction |
| alloc_ready | output | 1 | Queue can accept an instruction this cycle |
| alloc_op | input | OP_W | Opcode of the offered instruction |
| alloc_dst | input | TAG_W | Destination physical tag |
| alloc_src1 | input | TAG_W | First source tag |
| alloc_src1_rdy | input | 1 | First source already available |
| alloc_src2 | input | TAG_W | Second source tag |
| alloc_src2_rdy | input | 1 | Second source already available |
| alloc_rob | input | ROB_W | ROB index of the offered instruction |
| bcast_valid | input | BCAST_N | Per-port broadcast valid |
| bcast_tag | input | BCAST_N x TAG_W | Per-port broadcast destination tag |
| flush_valid | input | 1 | Remove entries younger than `flush_rob` |
| flush_rob | input | ROB_W | ROB index of the flush point |
| iss_valid | output | ISSUE_W | Per-slot issue valid |
| iss_op | output | ISSUE_W x OP_W | Per-slot opcode |
| iss_dst | output | ISSUE_W x TAG_W | Per-slot destination tag |
| iss_src1 | output | ISSUE_W x TAG_W | Per-slot first source tag |
| iss_src2 | output | ISSUE_W x TAG_W | Per-slot second source tag |
| iss_rob | output | ISSUE_W x ROB_W | Per-slot ROB index |

## Verification
On every cycle the assertions check several structural properties:
- each output slot selects at most one entry;
- no entry occupies two slots;
- valid slots are packed from slot 0;
- the age relation is never contradictory;
- an allocation lands in exactly one free entry;
- issued and flushed entries are empty one edge later;
- stored tags never change while an entry is occupied.

Only the bench's scenarios can show the remaining behaviour, because each depends on the history of inputs and on which instruction should be in which slot. That covers:
- oldest-first ranking across more ready entries than slots;
- same-cycle wakeup at allocation;
- the drop of an offer made while full;
- correct victims of a flush across the ROB index wrap.

// File: rtl/iq_pkg.sv
package iq_pkg;

    typedef enum logic [1:0] {
        ENT_FREE = 2'd0,
        ENT_WAIT = 2'd1,
        ENT_RDY  = 2'd2
    } ent_state_e;

endpackage

// File: rtl/iq_entry.sv
module iq_entry
    import iq_pkg::*;
#(
    parameter int TAG_W   = 7,
    parameter int OP_W    = 5,
    parameter int ROB_W   = 5,
    parameter int BCAST_N = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_we,
    input  logic [OP_W-1:0]               a_op,
    input  logic [TAG_W-1:0]              a_dst,
    input  logic [TAG_W-1:0]              a_src1,
    input  logic                          a_src1_rdy,
    input  logic [TAG_W-1:0]              a_src2,
    input  logic                          a_src2_rdy,
    input  logic [ROB_W-1:0]              a_rob,
    input  logic [BCAST_N-1:0]            bc_valid,
    input  logic [BCAST_N-1:0][TAG_W-1:0] bc_tag,
    input  logic                          flush_valid,
    input  logic [ROB_W-1:0]              flush_rob,
    input  logic                          grant,
    output logic                          is_free,
    output logic                          req,
    output logic [OP_W-1:0]               e_op,
    output logic [TAG_W-1:0]              e_dst,
    output logic [TAG_W-1:0]              e_src1,
    output logic [TAG_W-1:0]              e_src2,
    output logic [ROB_W-1:0]              e_rob
);

    ent_state_e state_q, state_d;
    logic r1_q, r1_d, r2_q, r2_d;
    logic [OP_W-1:0]  op_q;
    logic [TAG_W-1:0] dst_q, src1_q, src2_q;
    logic [ROB_W-1:0] rob_q;

    logic hit_s1, hit_s2, hit_a1, hit_a2;
    logic flush_hit;
    logic [ROB_W-1:0] rob_dist;

    // Tag comparators: stored sources and incoming allocation sources
    always_comb begin : wake_match
        hit_s1 = 1'b0;
        hit_s2 = 1'b0;
        hit_a1 = 1'b0;
        hit_a2 = 1'b0;
        for (int b = 0; b < BCAST_N; b++) begin
            if (bc_valid[b]) begin
                if (bc_tag[b] == src1_q) hit_s1 = 1'b1;
                if (bc_tag[b] == src2_q) hit_s2 = 1'b1;
                if (bc_tag[b] == a_src1) hit_a1 = 1'b1;
                if (bc_tag[b] == a_src2) hit_a2 = 1'b1;
            end
        end
    end

    // Younger than flush point: modular distance in the lower half, not zero
    assign rob_dist  = rob_q - flush_rob;
    assign flush_hit = flush_valid && (state_q != ENT_FREE)
                       && (rob_dist != '0) && !rob_dist[ROB_W-1];

    always_comb begin : next_state
        state_d = state_q;
        r1_d    = r1_q;
        r2_d    = r2_q;
        unique case (state_q)
            ENT_FREE: begin
                if (alloc_we) begin
                    r1_d    = a_src1_rdy | hit_a1;
                    r2_d    = a_src2_rdy | hit_a2;
                    state_d = (r1_d && r2_d) ? ENT_RDY : ENT_WAIT;
                end
            end
            ENT_WAIT: begin
                if (flush_hit) begin
                    state_d = ENT_FREE;
                end else begin
                    r1_d = r1_q | hit_s1;
                    r2_d = r2_q | hit_s2;
                    if (r1_d && r2_d) state_d = ENT_RDY;
                end
            end
            ENT_RDY: begin
                if (flush_hit || grant) state_d = ENT_FREE;
            end
            default: state_d = ENT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin : state_reg
        if (!rst_n) begin
            state_q <= ENT_FREE;
            r1_q    <= 1'b0;
            r2_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            r1_q    <= r1_d;
            r2_q    <= r2_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin : payload_reg
        if (!rst_n) begin
            op_q   <= '0;
            dst_q  <= '0;
            src1_q <= '0;
            src2_q <= '0;
            rob_q  <= '0;
        end else if (alloc_we && state_q == ENT_FREE) begin
            op_q   <= a_op;
            dst_q  <= a_dst;
            src1_q <= a_src1;
            src2_q <= a_src2;
            rob_q  <= a_rob;
        end
    end

    always_comb begin : outputs
        is_free = (state_q == ENT_FREE);
        req     = (state_q == ENT_RDY) && !flush_hit;
        e_op    = op_q;
        e_dst   = dst_q;
        e_src1  = src1_q;
        e_src2  = src2_q;
        e_rob   = rob_q;
    end

    // R7
    issue_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && grant) |=> is_free);

    // R8
    flush_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_hit |=> is_free);

    // R9
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_free |=> ($stable(e_src1) && $stable(e_src2) && $stable(e_dst)));

    // R3
    rdy_srcs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENT_RDY) |-> (r1_q && r2_q));

endmodule

// File: rtl/iq_age_matrix.sv
module iq_age_matrix #(
    parameter int DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DEPTH-1:0]            alloc_we,
    output logic [DEPTH-1:0][DEPTH-1:0] older_o
);

    // older_q[j][i] = 1 means entry j was allocated before entry i
    logic [DEPTH-1:0][DEPTH-1:0] older_q;

    always_ff @(posedge clk or negedge rst_n) begin : age_reg
        if (!rst_n) begin
            older_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc_we[i]) begin
                    for (int j = 0; j < DEPTH; j++) begin
                        older_q[i][j] <= 1'b0;
                        if (j != i) older_q[j][i] <= 1'b1;
                    end
                end
            end
        end
    end

    assign older_o = older_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        for (genvar j = i + 1; j < DEPTH; j++) begin : g_col
            // R6
            age_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(older_q[i][j] && older_q[j][i]));
        end
    end

endmodule

// File: rtl/iq_select.sv
module iq_select #(
    parameter int DEPTH   = 8,
    parameter int ISSUE_W = 3
) (
    input  logic [DEPTH-1:0]              req,
    input  logic [DEPTH-1:0][DEPTH-1:0]   older,
    output logic [ISSUE_W-1:0][DEPTH-1:0] grant
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] rank [DEPTH];

    // Rank of an entry = number of requesting entries older than it
    always_comb begin : rank_calc
        for (int i = 0; i < DEPTH; i++) begin
            rank[i] = '0;
            for (int j = 0; j < DEPTH; j++) begin
                if (req[j] && older[j][i]) rank[i] = rank[i] + 1'b1;
            end
        end
    end

    always_comb begin : slot_grant
        for (int k = 0; k < ISSUE_W; k++) begin
            for (int i = 0; i < DEPTH; i++) begin
                grant[k][i] = req[i] && (rank[i] == CNT_W'(k));
            end
        end
    end

endmodule

// File: rtl/wakeup_issue_queue.sv
module wakeup_issue_queue #(
    parameter int DEPTH   = 8,
    parameter int TAG_W   = 7,
    parameter int OP_W    = 5,
    parameter int ROB_W   = 5,
    parameter int ISSUE_W = 3,
    parameter int BCAST_N = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_valid,
    output logic                          alloc_ready,
    input  logic [OP_W-1:0]               alloc_op,
    input  logic [TAG_W-1:0]              alloc_dst,
    input  logic [TAG_W-1:0]              alloc_src1,
    input  logic                          alloc_src1_rdy,
    input  logic [TAG_W-1:0]              alloc_src2,
    input  logic                          alloc_src2_rdy,
    input  logic [ROB_W-1:0]              alloc_rob,
    input  logic [BCAST_N-1:0]            bcast_valid,
    input  logic [BCAST_N-1:0][TAG_W-1:0] bcast_tag,
    input  logic                          flush_valid,
    input  logic [ROB_W-1:0]              flush_rob,
    output logic [ISSUE_W-1:0]            iss_valid,
    output logic [ISSUE_W-1:0][OP_W-1:0]  iss_op,
    output logic [ISSUE_W-1:0][TAG_W-1:0] iss_dst,
    output logic [ISSUE_W-1:0][TAG_W-1:0] iss_src1,
    output logic [ISSUE_W-1:0][TAG_W-1:0] iss_src2,
    output logic [ISSUE_W-1:0][ROB_W-1:0] iss_rob
);

    logic [DEPTH-1:0] ent_free, ent_req, alloc_we, grant_any;
    logic [DEPTH-1:0][DEPTH-1:0]   older;
    logic [ISSUE_W-1:0][DEPTH-1:0] grant;
    logic [OP_W-1:0]  e_op   [DEPTH];
    logic [TAG_W-1:0] e_dst  [DEPTH];
    logic [TAG_W-1:0] e_src1 [DEPTH];
    logic [TAG_W-1:0] e_src2 [DEPTH];
    logic [ROB_W-1:0] e_rob  [DEPTH];
    logic accept;

    assign alloc_ready = (|ent_free) && !flush_valid;
    assign accept      = alloc_valid && alloc_ready;

    // Lowest-numbered free entry receives the allocation
    always_comb begin : slot_pick
        logic found;
        found    = 1'b0;
        alloc_we = '0;
        if (accept) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ent_free[i] && !found) begin
                    alloc_we[i] = 1'b1;
                    found       = 1'b1;
                end
            end
        end
    end

    always_comb begin : grant_merge
        for (int i = 0; i < DEPTH; i++) begin
            grant_any[i] = 1'b0;
            for (int k = 0; k < ISSUE_W; k++) grant_any[i] = grant_any[i] | grant[k][i];
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        iq_entry #(
            .TAG_W  (TAG_W),
            .OP_W   (OP_W),
            .ROB_W  (ROB_W),
            .BCAST_N(BCAST_N)
        ) ent_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_we   (alloc_we[i]),
            .a_op       (alloc_op),
            .a_dst      (alloc_dst),
            .a_src1     (alloc_src1),
            .a_src1_rdy (alloc_src1_rdy),
            .a_src2     (alloc_src2),
            .a_src2_rdy (alloc_src2_rdy),
            .a_rob      (alloc_rob),
            .bc_valid   (bcast_valid),
            .bc_tag     (bcast_tag),
            .flush_valid(flush_valid),
            .flush_rob  (flush_rob),
            .grant      (grant_any[i]),
            .is_free    (ent_free[i]),
            .req        (ent_req[i]),
            .e_op       (e_op[i]),
            .e_dst      (e_dst[i]),
            .e_src1     (e_src1[i]),
            .e_src2     (e_src2[i]),
            .e_rob      (e_rob[i])
        );
    end

    iq_age_matrix #(.DEPTH(DEPTH)) age_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .alloc_we(alloc_we),
        .older_o (older)
    );

    iq_select #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) sel_i (
        .req  (ent_req),
        .older(older),
        .grant(grant)
    );

    always_comb begin : issue_mux
        for (int k = 0; k < ISSUE_W; k++) begin
            iss_valid[k] = |grant[k];
            iss_op[k]    = '0;
            iss_dst[k]   = '0;
            iss_src1[k]  = '0;
            iss_src2[k]  = '0;
            iss_rob[k]   = '0;
            for (int i = 0; i < DEPTH; i++) begin
                if (grant[k][i]) begin
                    iss_op[k]   = iss_op[k]   | e_op[i];
                    iss_dst[k]  = iss_dst[k]  | e_dst[i];
                    iss_src1[k] = iss_src1[k] | e_src1[i];
                    iss_src2[k] = iss_src2[k] | e_src2[i];
                    iss_rob[k]  = iss_rob[k]  | e_rob[i];
                end
            end
        end
    end

    // R2
    alloc_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (($countones(alloc_we) == 1) && ((alloc_we & ~ent_free) == '0)));

    // R6
    slot_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_any) == $countones(iss_valid));

    // R6
    grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_any & ~ent_req) == '0);

    for (genvar k = 0; k < ISSUE_W; k++) begin : g_slot_chk
        // R6
        grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant[k]));
        if (k > 0) begin : g_pack
            // R6
            slot_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
                iss_valid[k] |-> iss_valid[k-1]);
        end
    end

endmodule

// File: tb/wakeup_issue_queue_tb_top.sv
module wakeup_issue_queue_tb_top;

    localparam int DEPTH   = 8;
    localparam int TAG_W   = 7;
    localparam int OP_W    = 5;
    localparam int ROB_W   = 5;
    localparam int ISSUE_W = 3;
    localparam int BCAST_N = 3;
    localparam int ROB_MASK = (1 << ROB_W) - 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                          rst_n;
    logic                          alloc_valid;
    logic                          alloc_ready;
    logic [OP_W-1:0]               alloc_op;
    logic [TAG_W-1:0]              alloc_dst, alloc_src1, alloc_src2;
    logic                          alloc_src1_rdy, alloc_src2_rdy;
    logic [ROB_W-1:0]              alloc_rob;
    logic [BCAST_N-1:0]            bcast_valid;
    logic [BCAST_N-1:0][TAG_W-1:0] bcast_tag;
    logic                          flush_valid;
    logic [ROB_W-1:0]              flush_rob;
    logic [ISSUE_W-1:0]            iss_valid;
    logic [ISSUE_W-1:0][OP_W-1:0]  iss_op;
    logic [ISSUE_W-1:0][TAG_W-1:0] iss_dst, iss_src1, iss_src2;
    logic [ISSUE_W-1:0][ROB_W-1:0] iss_rob;

    wakeup_issue_queue #(
        .DEPTH(DEPTH), .TAG_W(TAG_W), .OP_W(OP_W),
        .ROB_W(ROB_W), .ISSUE_W(ISSUE_W), .BCAST_N(BCAST_N)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
        .alloc_op(alloc_op), .alloc_dst(alloc_dst),
        .alloc_src1(alloc_src1), .alloc_src1_rdy(alloc_src1_rdy),
        .alloc_src2(alloc_src2), .alloc_src2_rdy(alloc_src2_rdy),
        .alloc_rob(alloc_rob),
        .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
        .flush_valid(flush_valid), .flush_rob(flush_rob),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_rob(iss_rob)
    );

    int checks   = 0;
    int failures = 0;

    // Behavioural reference: unordered pool with allocation sequence numbers
    bit m_v  [DEPTH];
    bit m_r1 [DEPTH];
    bit m_r2 [DEPTH];
    int m_seq[DEPTH];
    int m_op [DEPTH];
    int m_dst[DEPTH];
    int m_s1 [DEPTH];
    int m_s2 [DEPTH];
    int m_rob[DEPTH];
    int seq_ctr = 0;
    bit last_accept;

    function automatic bit younger(int rob, int frob);
        int d;
        d = (rob - frob) & ROB_MASK;
        return (d != 0) && (d < (1 << (ROB_W - 1)));
    endfunction

    function automatic bit bmatch(int tag);
        for (int b = 0; b < BCAST_N; b++)
            if (bcast_valid[b] && int'(bcast_tag[b]) == tag) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        alloc_valid    = 1'b0;
        alloc_op       = '0;
        alloc_dst      = '0;
        alloc_src1     = '0;
        alloc_src1_rdy = 1'b0;
        alloc_src2     = '0;
        alloc_src2_rdy = 1'b0;
        alloc_rob      = '0;
        bcast_valid    = '0;
        bcast_tag      = '0;
        flush_valid    = 1'b0;
        flush_rob      = '0;
    endtask

    task automatic set_alloc(int op, int dst, int s1, int s1r, int s2, int s2r, int rob);
        alloc_valid    = 1'b1;
        alloc_op       = OP_W'(op);
        alloc_dst      = TAG_W'(dst);
        alloc_src1     = TAG_W'(s1);
        alloc_src1_rdy = s1r[0];
        alloc_src2     = TAG_W'(s2);
        alloc_src2_rdy = s2r[0];
        alloc_rob      = ROB_W'(rob & ROB_MASK);
    endtask

    task automatic set_bc(int port, int tag);
        bcast_valid[port] = 1'b1;
        bcast_tag[port]   = TAG_W'(tag);
    endtask

    task automatic set_flush(int rob);
        flush_valid = 1'b1;
        flush_rob   = ROB_W'(rob & ROB_MASK);
    endtask

    // One cycle: compare outputs against the model, then advance the model
    task automatic step(string req);
        int  sel [ISSUE_W];
        bit  taken [DEPTH];
        bit  elig [DEPTH];
        int  nv;
        int  best;
        bit  exp_rdy;
        logic [63:0] expf;
        logic [63:0] actf;
        #1;
        nv = 0;
        for (int i = 0; i < DEPTH; i++) begin
            taken[i] = 1'b0;
            if (m_v[i]) nv++;
            elig[i] = m_v[i] && m_r1[i] && m_r2[i]
                      && !(flush_valid && younger(m_rob[i], int'(flush_rob)));
        end
        exp_rdy = (nv < DEPTH) && !flush_valid;
        for (int k = 0; k < ISSUE_W; k++) begin
            best = -1;
            for (int i = 0; i < DEPTH; i++)
                if (elig[i] && !taken[i] && (best < 0 || m_seq[i] < m_seq[best])) best = i;
            sel[k] = best;
            if (best >= 0) taken[best] = 1'b1;
        end
        chk(req, "alloc_ready", 64'(alloc_ready), 64'(exp_rdy));
        for (int k = 0; k < ISSUE_W; k++) begin
            chk(req, $sformatf("iss_valid[%0d]", k), 64'(iss_valid[k]), 64'(sel[k] >= 0));
            if (sel[k] >= 0) begin
                expf = 64'({OP_W'(m_op[sel[k]]), TAG_W'(m_dst[sel[k]]),
                            TAG_W'(m_s1[sel[k]]), TAG_W'(m_s2[sel[k]]),
                            ROB_W'(m_rob[sel[k]])});
                actf = 64'({iss_op[k], iss_dst[k], iss_src1[k], iss_src2[k], iss_rob[k]});
                chk(req, $sformatf("slot%0d fields", k), actf, expf);
            end
        end
        last_accept = alloc_valid && exp_rdy;
        @(posedge clk);
        for (int k = 0; k < ISSUE_W; k++)
            if (sel[k] >= 0) m_v[sel[k]] = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (m_v[i] && flush_valid && younger(m_rob[i], int'(flush_rob))) m_v[i] = 1'b0;
            if (m_v[i]) begin
                if (bmatch(m_s1[i])) m_r1[i] = 1'b1;
                if (bmatch(m_s2[i])) m_r2[i] = 1'b1;
            end
        end
        if (last_accept) begin
            best = -1;
            for (int i = 0; i < DEPTH; i++) if (!m_v[i] && best < 0) best = i;
            if (best >= 0) begin
                m_v[best]   = 1'b1;
                m_seq[best] = seq_ctr;
                seq_ctr++;
                m_op[best]  = int'(alloc_op);
                m_dst[best] = int'(alloc_dst);
                m_s1[best]  = int'(alloc_src1);
                m_s2[best]  = int'(alloc_src2);
                m_rob[best] = int'(alloc_rob);
                m_r1[best]  = alloc_src1_rdy || bmatch(int'(alloc_src1));
                m_r2[best]  = alloc_src2_rdy || bmatch(int'(alloc_src2));
            end
        end
        @(negedge clk);
        clear_in();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin : main
        int rob_ctr;
        int frob;
        bit fl;
        for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
        clear_in();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        step("R1");
        step("R1");

        // R3 / R10: both sources ready at allocation, issues next cycle
        set_alloc(3, 70, 1, 1, 2, 1, 1);
        step("R3");
        step("R10");
        step("R3");

        // R4: wakeup by broadcast
        set_alloc(4, 71, 40, 0, 3, 1, 2);
        step("R4");
        step("R4");
        step("R4");
        set_bc(0, 40);
        step("R4");
        step("R4");
        step("R4");

        // R5: broadcast in the allocation cycle
        set_alloc(5, 72, 41, 0, 42, 0, 3);
        set_bc(1, 41);
        set_bc(2, 42);
        step("R5");
        step("R5");
        step("R5");

        // R6: older waiting entry, five younger woken together
        set_alloc(6, 73, 51, 0, 4, 1, 4);
        step("R6");
        for (int n = 0; n < 5; n++) begin
            set_alloc(7 + n, 74 + n, 50, 0, 5, 1, 5 + n);
            step("R6");
        end
        set_bc(0, 50);
        step("R6");
        repeat (3) step("R6");
        set_bc(0, 51);
        step("R6");
        repeat (2) step("R6");

        // R2: fill, offer while full is dropped
        for (int n = 0; n < DEPTH; n++) begin
            set_alloc(n, 80 + n, 60, 0, 6, 1, 10 + n);
            step("R2");
        end
        set_alloc(9, 90, 60, 0, 6, 1, 18);
        step("R2");
        step("R2");
        set_bc(2, 60);
        step("R2");
        repeat (4) step("R2");

        // R8: flush in the middle of the window, with an offer held off
        for (int n = 0; n < 6; n++) begin
            set_alloc(n, 91 + n, 62, 0, 7, 1, 20 + n);
            step("R8");
        end
        set_flush(22);
        set_alloc(1, 99, 8, 1, 9, 1, 26);
        step("R8");
        set_bc(0, 62);
        step("R8");
        repeat (3) step("R8");

        // R8: flush across the ROB index wrap
        for (int n = 0; n < 4; n++) begin
            set_alloc(n, 100 + n, 63, 0, 7, 1, 30 + n);
            step("R8");
        end
        set_flush(31);
        step("R8");
        set_bc(1, 63);
        step("R8");
        repeat (3) step("R8");

        // R9: broadcasts do not rewrite tags; redundant broadcast is harmless
        set_alloc(9, 110, 44, 1, 45, 0, 2);
        step("R9");
        set_bc(0, 44);
        step("R9");
        set_bc(2, 110);
        step("R9");
        set_bc(1, 45);
        step("R9");
        repeat (2) step("R9");

        // R7: random traffic, each issued entry must appear once only
        rob_ctr = 3;
        for (int c = 0; c < 3000; c++) begin
            if ($urandom % 10 < 7)
                set_alloc(int'($urandom % 32), int'($urandom % 16), int'($urandom % 16),
                          int'($urandom % 2), int'($urandom % 16), int'($urandom % 2),
                          rob_ctr);
            for (int b = 0; b < BCAST_N; b++)
                if ($urandom % 10 < 4) set_bc(b, int'($urandom % 16));
            fl = ($urandom % 50) == 0;
            frob = 0;
            if (fl) begin
                frob = (rob_ctr - 1 - int'($urandom % 6)) & ROB_MASK;
                set_flush(frob);
            end
            step("R7");
            if (last_accept) rob_ctr = (rob_ctr + 1) & ROB_MASK;
            if (fl) rob_ctr = (frob + 1) & ROB_MASK;
        end
        repeat (4) step("R7");

        summary();
        $finish;
    end

endmodule